// File: doc/BRIEF.md
# Per-Lane Output Gating and Polarity Control

This block sits in front of the lane drivers of a parallel multi-lane transmitter. It holds four host-written control vectors, one bit per lane each: lane active, polarity invert, squelch permitted and margin mode. It also holds one sticky fault bit per lane. For every lane it decides, on each clock, whether the serial data bit is forwarded (after optional inversion) together with an output-enable, or whether the lane is held quiet.

A lane is held quiet when it is deactivated, when a fault is present or has been latched, or when its input signal is lost while squelch is permitted for that lane. A quiet lane drives data 0 with its enable low. The host loads all four control vectors at once with a write strobe. A synchronous control reset puts the controls back to their defaults and releases every latched fault. Margin mode only raises a per-lane status bit; data still passes through.

Top module: `lane_guard`

## Requirements
- R1: With output registering on (default), an enabled lane drives `lane_dout` equal to `lane_din XOR` its invert bit, and `lane_oe` high, one clock after the inputs are applied.
- R2: When `cfg_we` is high at a clock edge, the four control vectors are loaded from `cfg_active`, `cfg_invert`, `cfg_sq_en` and `cfg_margin`. They take effect on the output at the next edge.
- R3: A lane whose active bit is 0 drives `lane_dout` 0 and `lane_oe` 0.
- R4: A lane with `lane_los` high and its squelch-permitted bit 1 is quiet (dout 0, oe 0). With its squelch-permitted bit 0, the lane's data passes despite `lane_los`.
- R5: `lane_fault` high silences its lane on the same output update, and it latches. The lane stays quiet after `lane_fault` returns low.
- R6: A latched fault is released by `ctl_rst`, or by a clock edge at which the lane's active bit is 0. After reactivation the lane forwards data again.
- R7: `margin_active` shows each lane's margin bit. Lanes in margin mode forward data unchanged.
- R8: After `rst_n` low, or after a clock edge with `ctl_rst` high, all lanes are active, non-inverted and squelch-permitted, and margin is off. `ctl_rst` takes precedence over `cfg_we`.
- R9: Each lane is gated by its own controls and indicators only, without effect on other lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_rst | input | 1 | Synchronous control-register reset |
| cfg_we | input | 1 | Loads the four control vectors |
| cfg_active | input | LANES | Lane active bits to load |
| cfg_invert | input | LANES | Polarity invert bits to load |
| cfg_sq_en | input | LANES | Squelch-permitted bits to load |
| cfg_margin | input | LANES | Margin mode bits to load |
| lane_din | input | LANES | Per-lane serial data bit |
| lane_los | input | LANES | Per-lane loss of input signal |
| lane_fault | input | LANES | Per-lane fault indicator |
| lane_dout | output | LANES | Per-lane gated output data |
| lane_oe | output | LANES | Per-lane output-enable |
| margin_active | output | LANES | Per-lane margin status |

## Verification
The gating is tried with mixed data patterns under a partial invert mask. This separates inverted lanes from plain ones and shows the invert vector is not shifted or swapped. Loss of signal is applied to two lanes, one squelch-permitted and one not, so the squelch-permitted bit is seen deciding the result. A one-cycle fault pulse is followed by idle cycles to show the latch. The latch is then released both by control reset and by a deactivate/reactivate pair. Margin is checked on a subset of lanes, with data compared against the plain data.

// File: rtl/lane_guard_pkg.sv
package lane_guard_pkg;
   // default values of the per-lane control bits after any reset
   localparam logic DEF_ACTIVE = 1'b1;
   localparam logic DEF_INVERT = 1'b0;
   localparam logic DEF_SQ_EN  = 1'b1;
   localparam logic DEF_MARGIN = 1'b0;

   typedef struct packed {
      logic active;
      logic invert;
      logic sq_en;
      logic margin;
   } lane_ctl_t;

   localparam lane_ctl_t CTL_DEFAULT = '{active: DEF_ACTIVE, invert: DEF_INVERT,
                                         sq_en: DEF_SQ_EN, margin: DEF_MARGIN};
endpackage

// File: rtl/lane_ctl_regs.sv
module lane_ctl_regs
   import lane_guard_pkg::*;
#(
   parameter int LANES = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_rst,
   input  logic             we,
   input  logic [LANES-1:0] act_d,
   input  logic [LANES-1:0] inv_d,
   input  logic [LANES-1:0] sq_d,
   input  logic [LANES-1:0] mg_d,
   output lane_ctl_t        ctl_q [LANES]
);
   for (genvar g = 0; g < LANES; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       ctl_q[g] <= CTL_DEFAULT;
         else if (ctl_rst) ctl_q[g] <= CTL_DEFAULT;
         else if (we)      ctl_q[g] <= '{active: act_d[g], invert: inv_d[g],
                                         sq_en: sq_d[g], margin: mg_d[g]};
      end

      p_ctl_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
         $past(ctl_rst) |-> ctl_q[g] == CTL_DEFAULT);
      p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(we) && !$past(ctl_rst)) |-> ctl_q[g].active == $past(act_d[g]));
   end
endmodule

// File: rtl/lane_fault_hold.sv
module lane_fault_hold #(
   parameter int LANES = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [LANES-1:0] active,
   input  logic [LANES-1:0] fault,
   output logic [LANES-1:0] held
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   held <= '0;
      else if (clr) held <= '0;
      else          held <= (held | fault) & active;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_chk
      p_fault_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(fault[g]) && !$past(clr) && $past(active[g])) |-> held[g]);
      p_fault_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(clr) || !$past(active[g])) |-> !held[g]);
   end
endmodule

// File: rtl/lane_out_stage.sv
module lane_out_stage #(
   parameter bit REG_OUT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic inv,
   input  logic act,
   input  logic sq_en,
   input  logic los,
   input  logic fault_now,
   input  logic fault_held,
   output logic dout,
   output logic oe
);
   logic pass;
   logic dval;

   assign pass = act && !fault_now && !fault_held && !(los && sq_en);
   assign dval = pass ? (din ^ inv) : 1'b0;

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dout <= 1'b0;
            oe   <= 1'b0;
         end else begin
            dout <= dval;
            oe   <= pass;
         end
      end

      p_polarity_r1: assert property (@(posedge clk) disable iff (!rst_n)
         oe |-> dout == ($past(din) ^ $past(inv)));
      p_inactive_r3: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(act) |-> (!oe && !dout));
      p_squelch_r4: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(los) && $past(sq_en)) |-> !oe);
      p_fault_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
         $past(fault_now) |-> !oe);
   end else begin : g_comb
      assign dout = dval;
      assign oe   = pass;
   end
endmodule

// File: rtl/lane_guard.sv
module lane_guard
   import lane_guard_pkg::*;
#(
   parameter int LANES   = 12,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_rst,
   input  logic             cfg_we,
   input  logic [LANES-1:0] cfg_active,
   input  logic [LANES-1:0] cfg_invert,
   input  logic [LANES-1:0] cfg_sq_en,
   input  logic [LANES-1:0] cfg_margin,
   input  logic [LANES-1:0] lane_din,
   input  logic [LANES-1:0] lane_los,
   input  logic [LANES-1:0] lane_fault,
   output logic [LANES-1:0] lane_dout,
   output logic [LANES-1:0] lane_oe,
   output logic [LANES-1:0] margin_active
);
   localparam int MAX_LANES = 64;

   initial begin
      assert (LANES >= 1 && LANES <= MAX_LANES)
         else $error("lane_guard: LANES out of range");
   end

   lane_ctl_t        ctl [LANES];
   logic [LANES-1:0] act_v;
   logic [LANES-1:0] held;

   lane_ctl_regs #(.LANES(LANES)) u_regs (
      .clk(clk), .rst_n(rst_n), .ctl_rst(ctl_rst), .we(cfg_we),
      .act_d(cfg_active), .inv_d(cfg_invert), .sq_d(cfg_sq_en), .mg_d(cfg_margin),
      .ctl_q(ctl)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign act_v[g]         = ctl[g].active;
      assign margin_active[g] = ctl[g].margin;

      lane_out_stage #(.REG_OUT(REG_OUT)) u_out (
         .clk(clk), .rst_n(rst_n),
         .din(lane_din[g]), .inv(ctl[g].invert), .act(ctl[g].active),
         .sq_en(ctl[g].sq_en), .los(lane_los[g]),
         .fault_now(lane_fault[g]), .fault_held(held[g]),
         .dout(lane_dout[g]), .oe(lane_oe[g])
      );
   end

   lane_fault_hold #(.LANES(LANES)) u_hold (
      .clk(clk), .rst_n(rst_n), .clr(ctl_rst),
      .active(act_v), .fault(lane_fault), .held(held)
   );

   p_margin_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctl_rst) |-> margin_active == '0);
endmodule

// File: tb/lane_guard_test.sv
module lane_guard_test;
   localparam int N = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_rst = 1'b0, cfg_we = 1'b0;
   logic [N-1:0] cfg_active = '1, cfg_invert = '0, cfg_sq_en = '1, cfg_margin = '0;
   logic [N-1:0] lane_din = '0, lane_los = '0, lane_fault = '0;
   logic [N-1:0] lane_dout, lane_oe, margin_active;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   lane_guard #(.LANES(N)) uut (
      .clk(clk), .rst_n(rst_n), .ctl_rst(ctl_rst), .cfg_we(cfg_we),
      .cfg_active(cfg_active), .cfg_invert(cfg_invert), .cfg_sq_en(cfg_sq_en),
      .cfg_margin(cfg_margin), .lane_din(lane_din), .lane_los(lane_los),
      .lane_fault(lane_fault), .lane_dout(lane_dout), .lane_oe(lane_oe),
      .margin_active(margin_active)
   );

   task automatic check(string req, logic [N-1:0] got, logic [N-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   // load controls: strobe during one edge, returns at following negedge
   task automatic write_cfg(logic [N-1:0] a, logic [N-1:0] i, logic [N-1:0] s, logic [N-1:0] m);
      cfg_active = a; cfg_invert = i; cfg_sq_en = s; cfg_margin = m; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic t_reset();
      lane_din = 12'h3C3;
      @(negedge clk);
      check("R8 oe after reset", lane_oe, 12'hFFF);
      check("R8 data not inverted", lane_dout, 12'h3C3);
      check("R8 margin off", margin_active, 12'h000);
   endtask

   task automatic t_polarity();
      write_cfg(12'hFFF, 12'h0F0, 12'hFFF, 12'h000);
      lane_din = 12'hA5C;
      @(negedge clk);
      check("R1 R2 inverted lanes", lane_dout, 12'hAAC);
      lane_din = 12'h5A3;
      @(negedge clk);
      check("R1 second pattern", lane_dout, 12'h553);
      check("R1 oe", lane_oe, 12'hFFF);
   endtask

   task automatic t_deact();
      write_cfg(12'hFFE, 12'h000, 12'hFFF, 12'h000);
      lane_din = 12'hFFF;
      @(negedge clk);
      check("R3 oe lane0 off", lane_oe, 12'hFFE);
      check("R3 R9 dout", lane_dout, 12'hFFE);
   endtask

   task automatic t_los();
      write_cfg(12'hFFF, 12'h000, 12'hFFB, 12'h000);
      lane_din = 12'hFFF; lane_los = 12'h006;
      @(negedge clk);
      check("R4 oe los squelch", lane_oe, 12'hFFD);
      check("R4 R9 dout", lane_dout, 12'hFFD);
      lane_los = '0;
      @(negedge clk);
      check("R4 recover", lane_oe, 12'hFFF);
   endtask

   task automatic t_fault();
      write_cfg(12'hFFF, 12'h00F, 12'hFFF, 12'h000);
      lane_din = 12'hFFF; lane_fault = 12'h020;
      @(negedge clk);
      check("R5 immediate", lane_oe, 12'hFDF);
      lane_fault = '0;
      @(negedge clk);
      @(negedge clk);
      check("R5 sticky", lane_oe, 12'hFDF);
      check("R5 dout", lane_dout, 12'hFD0);
      ctl_rst = 1'b1; cfg_we = 1'b1; cfg_invert = 12'hFFF; cfg_active = '0;
      @(negedge clk);
      ctl_rst = 1'b0; cfg_we = 1'b0;
      @(negedge clk);
      check("R6 R8 ctl_rst release", lane_oe, 12'hFFF);
      check("R8 ctl_rst defaults win", lane_dout, 12'hFFF);
      lane_fault = 12'h080;
      @(negedge clk);
      lane_fault = '0;
      write_cfg(12'hF7F, 12'h000, 12'hFFF, 12'h000);
      write_cfg(12'hFFF, 12'h000, 12'hFFF, 12'h000);
      @(negedge clk);
      check("R6 reactivate", lane_oe, 12'hFFF);
   endtask

   task automatic t_margin();
      write_cfg(12'hFFF, 12'h000, 12'hFFF, 12'h00F);
      lane_din = 12'h96A;
      @(negedge clk);
      check("R7 status", margin_active, 12'h00F);
      check("R7 data unchanged", lane_dout, 12'h96A);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_polarity();
      t_deact();
      t_los();
      t_fault();
      t_margin();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog timeout");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule